// File: doc/BRIEF.md
# Noise-Shaped Duty Word Reducer

This block narrows a wide duty-cycle command to the few bits that a counter-based pulse-width modulator can resolve, without losing the resolution of the wide word on average. The upper bits of the command pass straight through. The lower bits, which the modulator cannot express, drive a two-stage cascade of first-order accumulators. The carries of the two stages are combined into a small signed correction that is added to the upper bits, so that the output toggles between neighbouring codes. Its mean follows the full-width command, and its error is pushed toward high frequencies, where the power stage filters it out.

The compensator presents a new command once per switching period, together with a one-cycle update strobe. On that strobe the block advances both accumulators and registers the corrected output. Between strobes the output holds, and changes on the command input are ignored. The corrected value is clamped to the output's code range, so that corrections cannot wrap at either end of the scale.

Top module: `mash_duty_trunc`

## Requirements
- R1: While reset is asserted, and on the first strobe after it, the block behaves as if both accumulators and the stored second-stage carry are zero, and `duty_out` reads 0.
- R2: `duty_out` changes only on the clock edge at which `upd` is high; at every other edge it holds its value.
- R3: On each strobe, the first stage adds the command's low 5 bits (`duty_in[4:0]`) to its 5-bit accumulator. Its carry c1 is the overflow out of bit 4.
- R4: On each strobe, the second stage adds the first stage's new 5-bit residue to its own 5-bit accumulator. Its carry c2 is the overflow out of bit 4, and c2 is stored for the next strobe.
- R5: The registered output is `duty_in[10:5]` + c1 + c2 − c2 of the previous strobe. It appears on `duty_out` right after the edge that sampled the strobe.
- R6: A result below 0 is clamped to 0.
- R7: A result above 63 is clamped to 63.
- R8: For a constant command whose upper field lies in 1 to 61, the sum of 1024 consecutive outputs, divided by 32, is within 1 of the 11-bit command.
- R9: The value of `duty_in` in cycles without a strobe has no effect on the output or on the accumulators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | One-cycle strobe, once per switching period |
| duty_in | input | 11 | Full-resolution duty command |
| duty_out | output | 6 | Registered reduced duty code |

## Verification
On every cycle, the embedded assertions check three things: that the output and the stored carry hold between strobes, that each new output stays inside the window from one code below to two codes above the sampled upper field, and that the clamps hold at both ends of the scale. The exact carry pattern, the cancellation of the delayed carry, the clamped sequences near zero and full scale, and the long-run mean can only be shown by the bench's scenarios. The bench compares every cycle against a behavioural model and sums 1024 outputs for several constant commands.

// File: rtl/mash_duty_trunc.sv
module mash_duty_trunc #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IN_W-1:0]  duty_in,
  output logic [OUT_W-1:0] duty_out
);
  localparam int FW = IN_W - OUT_W;
  localparam int SW = OUT_W + 3;
  localparam logic [SW-1:0] TOP = SW'((1 << OUT_W) - 1);

  logic [FW-1:0]    acc1, acc2;
  logic             c2_d;
  logic [FW:0]      s1, s2;
  logic             c1, c2;
  logic [OUT_W-1:0] hi;
  logic [SW-1:0]    sum;
  logic [OUT_W-1:0] sat;

  assign hi = duty_in[IN_W-1:FW];
  assign s1 = {1'b0, acc1} + {1'b0, duty_in[FW-1:0]};
  assign c1 = s1[FW];
  assign s2 = {1'b0, acc2} + {1'b0, s1[FW-1:0]};
  assign c2 = s2[FW];
  assign sum = {3'b000, hi} + SW'(c1) + SW'(c2) - SW'(c2_d);

  always_comb begin
    if (sum[SW-1])      sat = '0;
    else if (sum > TOP) sat = TOP[OUT_W-1:0];
    else                sat = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1     <= '0;
      acc2     <= '0;
      c2_d     <= 1'b0;
      duty_out <= '0;
    end else if (upd) begin
      acc1     <= s1[FW-1:0];
      acc2     <= s2[FW-1:0];
      c2_d     <= c2;
      duty_out <= sat;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(duty_out));

  p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(c2_d));

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ({3'b000, duty_out} + SW'(1) >= {3'b000, $past(hi)}) &&
            ({3'b000, duty_out} <= {3'b000, $past(hi)} + SW'(2)));

  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hi == '0) |=> duty_out <= OUT_W'(2));

  p_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && hi == TOP[OUT_W-1:0]) |=> duty_out >= TOP[OUT_W-1:0] - OUT_W'(1));
endmodule

// File: tb/sim_mash_duty_trunc.sv
module sim_mash_duty_trunc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        upd = 0;
  logic [10:0] duty_in = 0;
  logic [5:0]  duty_out;

  int checks = 0, errors = 0, cyc = 0;
  int a1 = 0, a2 = 0, c2p = 0, expv = 0;

  mash_duty_trunc u0 (.clk(clk), .rst_n(rst_n), .upd(upd), .duty_in(duty_in), .duty_out(duty_out));

  always #2 clk = ~clk;

  // behavioural reference, advanced on each sampling edge
  always @(posedge clk) begin
    if (!rst_n) begin
      a1 = 0; a2 = 0; c2p = 0; expv = 0;
    end else if (upd) begin
      int f, h, k1, k2, y;
      f = duty_in % 32; h = duty_in / 32;
      a1 = a1 + f; k1 = a1 / 32; a1 = a1 % 32;
      a2 = a2 + a1; k2 = a2 / 32; a2 = a2 % 32;
      y = h + k1 + k2 - c2p; c2p = k2;
      if (y < 0) y = 0;
      if (y > 63) y = 63;
      expv = y;
    end
  end

  // per-cycle comparison (R2, R5, R6, R7, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (duty_out !== expv[5:0]) begin
        errors++;
        $display("FAIL R5/R6/R7 cycle %0d got %0d expected %0d", cyc, duty_out, expv);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog got %0d cycles expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; upd = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  // one strobe, then gap idle cycles with scrambled command (R9)
  task automatic strobe(input int v, input int gap, output int q);
    @(negedge clk); duty_in = 11'(v); upd = 1;
    @(negedge clk); upd = 0; q = duty_out;
    for (int g = 0; g < gap; g++) begin
      duty_in = 11'(v ^ 11'h5a5 ^ g);
      @(negedge clk);
    end
  endtask

  task automatic mean_test(input int v, input int gap);
    int s = 0, q, d;
    do_reset();
    for (int i = 0; i < 1024; i++) begin
      strobe(v, gap, q);
      s += q;
    end
    d = s - v * 32;
    if (d < 0) d = -d;
    check("R8 mean error*32 within 32", (d <= 32) ? 1 : 0, 1);
  endtask

  initial begin
    int q;
    do_reset();
    @(negedge clk);
    check("R1 reset output", duty_out, 0);
    // hi=10, lo=16: outputs 10, 11, 11, 10
    strobe(10*32+16, 0, q); check("R1 first strobe from cleared state", q, 10);
    strobe(10*32+16, 2, q); check("R3 first-stage carry", q, 11);
    strobe(10*32+16, 1, q); check("R4 second-stage carry", q, 11);
    strobe(10*32+16, 0, q); check("R4 delayed carry cancels", q, 10);
    check("R2 hold after idle", duty_out, 10);
    // low clamp and high clamp sequences
    do_reset();
    for (int i = 0; i < 200; i++) strobe(7 + (i % 20), i % 2, q);
    check("R6 floor reached non-negative", (duty_out <= 2) ? 1 : 0, 1);
    do_reset();
    for (int i = 0; i < 200; i++) strobe(2047 - (i % 5), 0, q);
    check("R7 ceiling", (duty_out >= 62) ? 1 : 0, 1);
    strobe(2047, 0, q); check("R7 full scale saturates", q, 63);
    mean_test(1000, 0);
    mean_test(32 + 1, 1);
    mean_test(61*32 + 31, 0);
    mean_test(555, 2);
    mean_test(1024 + 17, 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule